// File: doc/BRIEF.md
# Fractional Baud Divisor Search Engine

This block finds the divisor settings for a serial port whose bit clock comes from a 16x oversampled integer divider followed by a fractional multiplier stage. Given a reference clock frequency and a wanted line rate, it tries every legal (multiplier, add) pair of the fractional stage. For each pair it works out the nearest integer divisor and how far that divisor is from the exact value. It keeps the pair whose divisor gives the smallest error.

A pulse on `start_i` captures the two operands and begins the search. `busy_o` is high while the search runs. Each candidate is found with a serial restoring divider that needs one cycle per quotient bit, so no wide combinational divider is used. When the search ends, `done_o` rises and the winning triple stays on the outputs until the next start. If no pair yields a divisor in the legal range, `no_fit_o` is raised together with `done_o`.

Top module: `baud_divisor_search`

## Requirements
- R1: Pairs are tried with the multiplier `mul` stepping from 1 to 15 in the outer loop and the add value `add` stepping from 0 to `mul`-1 in the inner loop, so that `add < mul` always holds.
- R2: For each pair, a 64-bit quotient Q = (F << 28) * mul / ((mul + add) * B) is formed, where F is `base_hz_i` and B is `rate_i` as captured at start. Q[63:32] is the raw divisor and Q[31:0] is the raw error.
- R3: When the raw error is strictly greater than 2^31, the divisor is incremented by one and the error is replaced by its 32-bit two's-complement negation. Otherwise both are used unchanged.
- R4: A candidate whose divisor is below 1 or above 65536 is discarded. A reported divisor `dl_o` therefore always lies in [1, 65536].
- R5: A candidate replaces the stored best only when its error is strictly smaller than the stored error, so on a tie the earlier pair in R1 order is kept. `resid_o` never increases during a search.
- R6: The search stops as soon as a candidate with zero error is stored. For an exact first pair, `done_o` rises within 80 cycles of start.
- R7: At start the stored error is 32'hFFFFFFFF and the stored triple is zero. If no candidate is in range, `done_o` and `no_fit_o` both rise, with `dl_o`, `mul_o` and `add_o` equal to 0 and `resid_o` equal to 32'hFFFFFFFF.
- R8: `start_i` is ignored while `busy_o` is high. The result depends only on the operands present at the accepted start.
- R9: From the rise of `done_o` until the next accepted start, `done_o` stays high and `dl_o`, `mul_o`, `add_o`, `resid_o` and `no_fit_o` hold their values, even if the operand inputs change.
- R10: After reset, `busy_o`, `done_o` and `no_fit_o` are low, and `dl_o`, `mul_o` and `add_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse; captures operands when idle or done |
| base_hz_i | input | 32 | Reference clock frequency in Hz |
| rate_i | input | 32 | Wanted line rate in baud |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | Result valid; held until next start |
| no_fit_o | output | 1 | No legal divisor was found |
| dl_o | output | 17 | Winning integer divisor (1..65536, or 0 if none) |
| mul_o | output | 4 | Winning fractional multiplier |
| add_o | output | 4 | Winning fractional add value |
| resid_o | output | 32 | Residual error of the winning candidate |

## Verification
The search is run on the following cases:
- Common reference clocks and standard line rates, where only the round-to-nearest rule and the strict-less replacement pick the winner among close candidates.
- An operand pair that is exact on the very first pair, to tell the early stop apart from a full sweep by the cycles to `done_o`.
- Rates that are too high and too low for any divisor, to separate the lower and the upper range bounds.
- A second start and operand change in the middle of a search, which must leave the first result untouched.
- A hold period with changing operands after completion, which must not disturb the stored result.

// File: rtl/baud_search_pkg.sv
package baud_search_pkg;
   typedef enum logic [1:0] {
      S_IDLE = 2'd0,
      S_LOAD = 2'd1,
      S_WAIT = 2'd2,
      S_DONE = 2'd3
   } search_state_t;
endpackage

// File: rtl/bds_serial_div.sv
module bds_serial_div #(
   parameter int NW = 64,
   parameter int DW = 37
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go_i,
   input  logic [NW-1:0] num_i,
   input  logic [DW-1:0] den_i,
   output logic          busy_o,
   output logic          fin_o,
   output logic [NW-1:0] quo_o
);
   localparam int CW = $clog2(NW + 1);

   logic [NW-1:0] q_q;
   logic [DW-1:0] r_q;
   logic [DW-1:0] den_q;
   logic [CW-1:0] cnt_q;
   logic          busy_q;
   logic          fin_q;
   logic [DW:0]   trial;
   logic [DW:0]   diff;
   logic          ge;

   generate
      if (NW < 2) begin : g_bad_nw
         $error("bds_serial_div: NW must be at least 2");
      end
   endgenerate

   always_comb begin
      trial = {r_q, q_q[NW-1]};
      ge    = trial >= {1'b0, den_q};
      diff  = trial - {1'b0, den_q};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_q    <= '0;
         r_q    <= '0;
         den_q  <= '0;
         cnt_q  <= '0;
         busy_q <= 1'b0;
         fin_q  <= 1'b0;
      end else begin
         fin_q <= 1'b0;
         if (go_i) begin
            q_q    <= num_i;
            r_q    <= '0;
            den_q  <= den_i;
            cnt_q  <= CW'(NW);
            busy_q <= 1'b1;
         end else if (busy_q) begin
            q_q   <= {q_q[NW-2:0], ge};
            r_q   <= ge ? diff[DW-1:0] : trial[DW-1:0];
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CW'(1)) begin
               busy_q <= 1'b0;
               fin_q  <= 1'b1;
            end
         end
      end
   end

   assign busy_o = busy_q;
   assign fin_o  = fin_q;
   assign quo_o  = q_q;

   // R2
   rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && den_q != '0) |-> (r_q < den_q));

   // R2
   fin_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_q) |-> fin_q);
endmodule

// File: rtl/bds_pair_walk.sv
module bds_pair_walk #(
   parameter int MUL_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             init_i,
   input  logic             step_i,
   output logic [MUL_W-1:0] mul_o,
   output logic [MUL_W-1:0] add_o,
   output logic             last_o
);
   localparam logic [MUL_W-1:0] MUL_LAST = {MUL_W{1'b1}};

   logic [MUL_W-1:0] mul_q;
   logic [MUL_W-1:0] add_q;
   logic             wrap;

   assign wrap   = (add_q == mul_q - 1'b1);
   assign last_o = wrap && (mul_q == MUL_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mul_q <= MUL_W'(1);
         add_q <= '0;
      end else if (init_i) begin
         mul_q <= MUL_W'(1);
         add_q <= '0;
      end else if (step_i && !last_o) begin
         if (wrap) begin
            mul_q <= mul_q + 1'b1;
            add_q <= '0;
         end else begin
            add_q <= add_q + 1'b1;
         end
      end
   end

   assign mul_o = mul_q;
   assign add_o = add_q;

   // R1
   pair_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mul_q != '0) && (add_q < mul_q));

   // R1
   pair_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !init_i && wrap && !last_o) |=>
         (add_q == '0) && (mul_q == $past(mul_q) + 1'b1));
endmodule

// File: rtl/bds_judge.sv
module bds_judge #(
   parameter int QW     = 64,
   parameter int FRAC_W = 32,
   parameter int DL_LOG = 16
) (
   input  logic [QW-1:0]        quo_i,
   input  logic [FRAC_W-1:0]    best_i,
   output logic [QW-FRAC_W-1:0] cdl_o,
   output logic [FRAC_W-1:0]    cerr_o,
   output logic                 take_o,
   output logic                 exact_o
);
   localparam int HW = QW - FRAC_W;
   localparam logic [FRAC_W-1:0] HALF   = FRAC_W'(1) << (FRAC_W - 1);
   localparam logic [HW-1:0]     DL_MAX = HW'(1) << DL_LOG;

   logic [FRAC_W-1:0] lo;
   logic [HW-1:0]     hi;
   logic              in_range;

   generate
      if (HW <= DL_LOG) begin : g_bad_hw
         $error("bds_judge: integer part too narrow for divisor range");
      end
   endgenerate

   always_comb begin
      lo = quo_i[FRAC_W-1:0];
      hi = quo_i[QW-1:FRAC_W];
      if (lo > HALF) begin
         cerr_o = ~lo + 1'b1;
         cdl_o  = hi + 1'b1;
      end else begin
         cerr_o = lo;
         cdl_o  = hi;
      end
      in_range = (cdl_o >= HW'(1)) && (cdl_o <= DL_MAX);
      take_o   = in_range && (cerr_o < best_i);
      exact_o  = take_o && (cerr_o == '0);
   end
endmodule

// File: rtl/baud_divisor_search.sv
module baud_divisor_search #(
   parameter int CLK_W         = 32,
   parameter int RATE_W        = 32,
   parameter int FRAC_W        = 32,
   parameter int OVS_LOG       = 4,
   parameter int MUL_W         = 4,
   parameter int DL_LOG        = 16,
   parameter bit STOP_ON_EXACT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [CLK_W-1:0]  base_hz_i,
   input  logic [RATE_W-1:0] rate_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              no_fit_o,
   output logic [DL_LOG:0]   dl_o,
   output logic [MUL_W-1:0]  mul_o,
   output logic [MUL_W-1:0]  add_o,
   output logic [FRAC_W-1:0] resid_o
);
   import baud_search_pkg::*;

   localparam int SHIFT = FRAC_W - OVS_LOG;
   localparam int QW    = CLK_W + SHIFT + MUL_W;
   localparam int HW    = QW - FRAC_W;
   localparam int DVW   = RATE_W + MUL_W + 1;
   localparam int DLW   = DL_LOG + 1;

   generate
      if (FRAC_W <= OVS_LOG) begin : g_bad_frac
         $error("baud_divisor_search: FRAC_W must exceed OVS_LOG");
      end
      if (MUL_W < 1) begin : g_bad_mul
         $error("baud_divisor_search: MUL_W must be at least 1");
      end
   endgenerate

   search_state_t     state_q;
   logic [CLK_W-1:0]  base_q;
   logic [RATE_W-1:0] rate_q;
   logic [FRAC_W-1:0] best_q;
   logic [DLW-1:0]    dl_q;
   logic [MUL_W-1:0]  mul_q;
   logic [MUL_W-1:0]  add_q;
   logic              found_q;

   logic              accept;
   logic [MUL_W-1:0]  w_mul;
   logic [MUL_W-1:0]  w_add;
   logic              w_last;
   logic              w_step;
   logic [QW-1:0]     num;
   logic [DVW-1:0]    den;
   logic              div_go;
   logic              div_busy;
   logic              div_fin;
   logic [QW-1:0]     quo;
   logic [HW-1:0]     cdl;
   logic [FRAC_W-1:0] cerr;
   logic              take;
   logic              exact;
   logic              stop_now;

   assign accept = start_i && (state_q == S_IDLE || state_q == S_DONE);
   assign div_go = (state_q == S_LOAD);
   assign w_step = (state_q == S_WAIT) && div_fin;

   always_comb begin
      num = (QW'(base_q) << SHIFT) * QW'(w_mul);
      den = DVW'({1'b0, w_mul} + {1'b0, w_add}) * DVW'(rate_q);
   end

   generate
      if (STOP_ON_EXACT) begin : g_stop
         assign stop_now = exact;
      end else begin : g_sweep
         assign stop_now = 1'b0;
      end
   endgenerate

   bds_pair_walk #(.MUL_W(MUL_W)) u_walk (
      .clk    (clk),
      .rst_n  (rst_n),
      .init_i (accept),
      .step_i (w_step),
      .mul_o  (w_mul),
      .add_o  (w_add),
      .last_o (w_last)
   );

   bds_serial_div #(.NW(QW), .DW(DVW)) u_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .go_i   (div_go),
      .num_i  (num),
      .den_i  (den),
      .busy_o (div_busy),
      .fin_o  (div_fin),
      .quo_o  (quo)
   );

   bds_judge #(.QW(QW), .FRAC_W(FRAC_W), .DL_LOG(DL_LOG)) u_judge (
      .quo_i   (quo),
      .best_i  (best_q),
      .cdl_o   (cdl),
      .cerr_o  (cerr),
      .take_o  (take),
      .exact_o (exact)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         base_q  <= '0;
         rate_q  <= '0;
         best_q  <= '1;
         dl_q    <= '0;
         mul_q   <= '0;
         add_q   <= '0;
         found_q <= 1'b0;
      end else begin
         case (state_q)
            S_IDLE, S_DONE: begin
               if (accept) begin
                  base_q  <= base_hz_i;
                  rate_q  <= rate_i;
                  best_q  <= '1;
                  dl_q    <= '0;
                  mul_q   <= '0;
                  add_q   <= '0;
                  found_q <= 1'b0;
                  state_q <= S_LOAD;
               end
            end
            S_LOAD: state_q <= S_WAIT;
            S_WAIT: begin
               if (div_fin) begin
                  if (take) begin
                     best_q  <= cerr;
                     dl_q    <= cdl[DLW-1:0];
                     mul_q   <= w_mul;
                     add_q   <= w_add;
                     found_q <= 1'b1;
                  end
                  state_q <= (stop_now || w_last) ? S_DONE : S_LOAD;
               end
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

   assign busy_o   = (state_q == S_LOAD) || (state_q == S_WAIT);
   assign done_o   = (state_q == S_DONE);
   assign no_fit_o = done_o && !found_q;
   assign dl_o     = dl_q;
   assign mul_o    = mul_q;
   assign add_o    = add_q;
   assign resid_o  = best_q;

   // R9
   hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !start_i) |=> (done_o && $stable(dl_o) && $stable(mul_o)
         && $stable(add_o) && $stable(resid_o) && $stable(no_fit_o)));

   // R4
   dl_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !no_fit_o) |-> (dl_o != '0) && (dl_o <= (DLW'(1) << DL_LOG)));

   // R7
   nofit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && no_fit_o) |-> (dl_o == '0) && (mul_o == '0)
         && (add_o == '0) && (resid_o == '1));

   // R5
   best_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_WAIT) |=> (resid_o <= $past(resid_o)));

   // R8
   start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i) |=> (busy_o || done_o) && $stable(base_q) && $stable(rate_q));

   // R2
   div_idle_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_LOAD) |-> !div_busy);
endmodule

// File: tb/sim_baud_divisor_search.sv
`timescale 1ns/1ps
module sim_baud_divisor_search;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [31:0] base_hz_i = '0;
   logic [31:0] rate_i = '0;
   logic        busy_o, done_o, no_fit_o;
   logic [16:0] dl_o;
   logic [3:0]  mul_o, add_o;
   logic [31:0] resid_o;

   int errors = 0;
   int checks = 0;
   int cycles = 0;

   logic        mon_en = 1'b0;
   logic [16:0] exp_dl;
   logic [3:0]  exp_mul, exp_add;
   logic [31:0] exp_err;
   logic        exp_nf;
   string       exp_tag = "";

   always #2 clk = ~clk;

   baud_divisor_search u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_hz_i(base_hz_i),
      .rate_i(rate_i), .busy_o(busy_o), .done_o(done_o), .no_fit_o(no_fit_o),
      .dl_o(dl_o), .mul_o(mul_o), .add_o(add_o), .resid_o(resid_o)
   );

   task automatic note(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
      end
   endtask

   // Behavioural reference of the whole search (R1..R7)
   task automatic ref_search(input logic [31:0] b, input logic [31:0] r,
                             output logic [16:0] dl, output logic [3:0] m,
                             output logic [3:0] a, output logic [31:0] e,
                             output logic nf);
      logic [31:0] best;
      bit stop;
      best = 32'hFFFF_FFFF; dl = '0; m = '0; a = '0; stop = 1'b0;
      for (int cm = 1; cm < 16; cm++) begin
         for (int ca = 0; ca < cm; ca++) begin
            logic [63:0] q;
            logic [31:0] lo, hi;
            if (!stop) begin
               q  = ({32'b0, b} << 28) * 64'(cm) / (64'(cm + ca) * 64'(r));
               lo = q[31:0];
               hi = q[63:32];
               if (lo > 32'h8000_0000) begin
                  lo = -lo;
                  hi = hi + 1;
               end
               if (hi >= 1 && hi <= 65536 && lo < best) begin
                  best = lo; dl = hi[16:0]; m = 4'(cm); a = 4'(ca);
                  if (lo == 0) stop = 1'b1;
               end
            end
         end
      end
      e = best;
      nf = (dl == 0);
   endtask

   // Per-clock comparison against the model whenever a result is shown (R9)
   always @(negedge clk) begin
      if (mon_en && done_o) begin
         note(dl_o == exp_dl, exp_tag, "dl", dl_o, exp_dl);
         note(mul_o == exp_mul, exp_tag, "mul", mul_o, exp_mul);
         note(add_o == exp_add, exp_tag, "add", add_o, exp_add);
         note(resid_o == exp_err, exp_tag, "resid", resid_o, exp_err);
         note(no_fit_o == exp_nf, exp_tag, "no_fit", no_fit_o, exp_nf);
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 190000) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 190000);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   task automatic launch(input logic [31:0] b, input logic [31:0] r, input string tag);
      logic [16:0] d; logic [3:0] m, a; logic [31:0] e; logic nf;
      ref_search(b, r, d, m, a, e, nf);
      @(posedge clk); #1;
      base_hz_i = b; rate_i = r; start_i = 1'b1;
      @(posedge clk); #1;
      start_i = 1'b0;
      exp_dl = d; exp_mul = m; exp_add = a; exp_err = e; exp_nf = nf;
      exp_tag = tag;
      mon_en = 1'b1;
   endtask

   task automatic wait_done(output int n);
      n = 0;
      @(negedge clk);
      while (!done_o && n < 20000) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic run_case(input logic [31:0] b, input logic [31:0] r, input string tag);
      int n;
      launch(b, r, tag);
      wait_done(n);
      note(done_o == 1'b1, tag, "done reached", done_o, 1);
   endtask

   initial begin
      int n;
      repeat (3) @(posedge clk);
      #1;
      // R10 reset state
      note(busy_o == 1'b0, "R10", "busy after reset", busy_o, 0);
      note(done_o == 1'b0, "R10", "done after reset", done_o, 0);
      note(no_fit_o == 1'b0, "R10", "no_fit in reset", no_fit_o, 0);
      note(dl_o == '0 && mul_o == '0 && add_o == '0, "R10", "triple in reset", dl_o, 0);
      rst_n = 1'b1;
      @(negedge clk);
      note(busy_o == 1'b0 && done_o == 1'b0, "R10", "idle after release", busy_o, 0);

      // R1 R2 R3 R5: common clocks and rates, full sweeps
      run_case(32'd12_000_000, 32'd115_200, "R2");
      run_case(32'd48_000_000, 32'd9_600, "R3");
      run_case(32'd204_000_000, 32'd115_200, "R5");
      run_case(32'd30_000_000, 32'd38_400, "R1");

      // R6 exact on the first pair: early stop
      launch(32'd1_536_000, 32'd9_600, "R6");
      wait_done(n);
      note(n <= 80, "R6", "cycles to done on exact pair", n, 80);
      note(resid_o == 32'd0 && mul_o == 4'd1 && add_o == 4'd0 && dl_o == 17'd10,
           "R6", "exact winner dl", dl_o, 10);

      // R4 R7 rate too high: divisor below 1
      run_case(32'd1_000, 32'd1_000_000, "R7");
      note(no_fit_o == 1'b1, "R7", "no_fit low bound", no_fit_o, 1);
      // R4 R7 rate too low: divisor above 65536
      run_case(32'd100_000_000, 32'd10, "R4");
      note(no_fit_o == 1'b1 && dl_o == '0, "R4", "no_fit high bound", no_fit_o, 1);

      // R9 hold while operands change without start
      run_case(32'd25_000_000, 32'd31_250, "R9");
      for (int i = 0; i < 20; i++) begin
         @(posedge clk); #1;
         base_hz_i = base_hz_i + 32'd7;
         rate_i = rate_i + 32'd3;
      end
      @(negedge clk);
      note(done_o == 1'b1, "R9", "done held", done_o, 1);

      // R8 start during busy is ignored
      launch(32'd12_000_000, 32'd57_600, "R8");
      repeat (500) @(posedge clk);
      #1;
      note(busy_o == 1'b1, "R8", "busy mid search", busy_o, 1);
      base_hz_i = 32'd1_000; rate_i = 32'd1_000_000; start_i = 1'b1;
      @(posedge clk); #1;
      start_i = 1'b0;
      wait_done(n);
      note(no_fit_o == 1'b0, "R8", "result from first operands", no_fit_o, 0);

      @(negedge clk);
      mon_en = 1'b0;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule